// File: doc/BRIEF.md
# Dual-Bank Clocked-Select Multiplexer with Last-Value Hold

This block holds the control and data path for one group of a two-bank 4:1 selector, written as one-way digital logic. Each bank routes one of four input ports onto its output. Both banks are steered by one shared two-bit port select. A mode input chooses how that select takes effect. In registered mode it is captured on the rising clock edge, but only while an active-low capture enable is asserted. In direct mode it steers the banks without the clock.

Each bank has its own active-low output enable. When the enable is released, the bank's switches open in the same cycle, whatever the capture enable is doing. The output then keeps the last value the bank passed. Moving from one port to another is break-before-make. When the effective select changes while a bank is on, the bank spends one cycle with every switch open and shows its held value. The new port connects in the next cycle. Each bank reports a per-port switch-enable vector and a hold flag.

Top module: `dualbank_selmux`

## Requirements
- R1: Select code 0 connects port A, 1 port B, 2 port C and 3 port D, with sel_i[0] as the low bit. Port p of bank b occupies port_data_i[(b*NPORT+p)*DATA_W +: DATA_W], and bank b's output is y_o[b*DATA_W +: DATA_W].
- R2: With sync_mode_i high (registered mode), sel_i is taken into the select register at a rising clock edge only while clk_en_n_i is low. Before that edge, the connection does not change.
- R3: In registered mode with clk_en_n_i high, the select register keeps its contents. The connected port stays the same, and the output follows that port's current data.
- R4: With sync_mode_i low (direct mode), sel_i steers the banks without the select register.
- R5: Setting oe_n_i[b] high opens every switch of bank b in the same cycle, in either mode. It does not disturb the select register. When oe_n_i[b] goes low again and the select has not changed, the bank reconnects in that cycle without a dark cycle.
- R6: While bank b is off, its output holds the value it passed at the last clock edge at which it was connected, even if its input data changes.
- R7: When the effective select of an enabled bank differs from the one in force in the previous cycle, the bank has exactly one cycle with all switch enables low, showing its held value. The newly selected port is passed in the next cycle.
- R8: sw_en_o[b*NPORT+p] is high only when port p of bank b is connected. At most one bit per bank is high, and hold_o[b] is high exactly when none is.
- R9: A synchronous high rst_i sets the select register to port A, the connection tracker of each bank to port A, and each held value to zero.
- R10: The enable and hold state of one bank does not affect the other bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| sync_mode_i | input | 1 | 1 = registered select, 0 = direct select |
| clk_en_n_i | input | 1 | Select-register capture enable, active low |
| sel_i | input | SEL_W | Shared port select |
| oe_n_i | input | NBANK | Per-bank output enable, active low |
| port_data_i | input | NBANK*NPORT*DATA_W | All input ports, bank-major |
| y_o | output | NBANK*DATA_W | Bank outputs |
| sw_en_o | output | NBANK*NPORT | Per-port switch enables, one-hot or zero per bank |
| hold_o | output | NBANK | Bank is showing its held value |

## Verification
Each bank is given a distinct data byte on every port, so the output value identifies the connected port directly. A held value can be told apart from a live one because the bench changes port data while a bank is off or is only holding. Select changes are applied in direct mode and in registered mode. The bench probes before and after the capturing edge, which separates the extra cycle of latency in registered mode from the break-before-make cycle. Further sequences toggle the capture enable and each output enable alone, showing that the register is kept, that the off control overrides the select, and that one bank does not affect the other.

// File: rtl/dbm_pkg.sv
package dbm_pkg;

  typedef enum logic {
    MODE_DIRECT = 1'b0,
    MODE_REGD   = 1'b1
  } sel_mode_e;

  // One-hot decode of a port index; callers cut it to their port count.
  function automatic logic [31:0] port_onehot(input int unsigned idx);
    return 32'(1) << idx;
  endfunction

endpackage

// File: rtl/dbm_sel_stage.sv
module dbm_sel_stage #(
  parameter int SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             sync_mode_i,
  input  logic             clk_en_n_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [SEL_W-1:0] eff_sel_o
);
  import dbm_pkg::*;

  logic [SEL_W-1:0] sel_q;
  logic             regd_mode;
  logic             capture_w;

  assign regd_mode = (sync_mode_i == MODE_REGD);
  assign capture_w = regd_mode && !clk_en_n_i;

  always_ff @(posedge clk_i) begin
    if (rst_i)          sel_q <= '0;
    else if (capture_w) sel_q <= sel_i;
  end

  assign eff_sel_o = regd_mode ? sel_q : sel_i;

  // R2
  sel_capture_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    capture_w |=> (sel_q == $past(sel_i)));

  // R3
  sel_keep_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !capture_w |=> $stable(sel_q));

endmodule

// File: rtl/dbm_bank.sv
module dbm_bank #(
  parameter int NPORT  = 4,
  parameter int DATA_W = 8,
  parameter int SEL_W  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_i,
  input  logic                    oe_n_i,
  input  logic [SEL_W-1:0]        eff_sel_i,
  input  logic [NPORT*DATA_W-1:0] port_i,
  output logic [DATA_W-1:0]       y_o,
  output logic [NPORT-1:0]        sw_en_o,
  output logic                    hold_o
);
  import dbm_pkg::*;

  logic [SEL_W-1:0]  conn_q;
  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] picked_w;
  logic              bank_on;
  logic              sel_moved;
  logic              break_w;
  logic              link_w;

  assign bank_on   = !oe_n_i;
  assign sel_moved = (eff_sel_i != conn_q);
  assign break_w   = bank_on && sel_moved;
  assign link_w    = bank_on && !sel_moved;
  assign picked_w  = port_i[eff_sel_i*DATA_W +: DATA_W];

  assign sw_en_o = link_w ? NPORT'(port_onehot(int'(eff_sel_i))) : '0;
  assign y_o     = link_w ? picked_w : hold_q;
  assign hold_o  = !link_w;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      conn_q <= '0;
      hold_q <= '0;
    end else begin
      conn_q <= eff_sel_i;
      if (link_w) hold_q <= picked_w;
    end
  end

  // R8
  sw_onehot_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0(sw_en_o));

  // R7
  bbm_dark_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (bank_on && !$past(rst_i) && (eff_sel_i != $past(eff_sel_i))) |-> (sw_en_o == '0));

  // R6
  held_value_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (hold_o && !$past(rst_i)) |-> (y_o == $past(y_o)));

  // R7
  break_shows_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    break_w |-> (hold_o && (y_o == hold_q)));

endmodule

// File: rtl/dualbank_selmux.sv
module dualbank_selmux #(
  parameter int NBANK  = 2,
  parameter int NPORT  = 4,
  parameter int DATA_W = 8,
  localparam int SEL_W = $clog2(NPORT),
  localparam int BANK_DW = NPORT * DATA_W
) (
  input  logic                      clk_i,
  input  logic                      rst_i,
  input  logic                      sync_mode_i,
  input  logic                      clk_en_n_i,
  input  logic [SEL_W-1:0]          sel_i,
  input  logic [NBANK-1:0]          oe_n_i,
  input  logic [NBANK*BANK_DW-1:0]  port_data_i,
  output logic [NBANK*DATA_W-1:0]   y_o,
  output logic [NBANK*NPORT-1:0]    sw_en_o,
  output logic [NBANK-1:0]          hold_o
);

  logic [SEL_W-1:0] eff_sel;

  dbm_sel_stage #(.SEL_W(SEL_W)) sel_stage_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .sync_mode_i (sync_mode_i),
    .clk_en_n_i  (clk_en_n_i),
    .sel_i       (sel_i),
    .eff_sel_o   (eff_sel)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    dbm_bank #(
      .NPORT  (NPORT),
      .DATA_W (DATA_W),
      .SEL_W  (SEL_W)
    ) bank_i (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .oe_n_i    (oe_n_i[b]),
      .eff_sel_i (eff_sel),
      .port_i    (port_data_i[b*BANK_DW +: BANK_DW]),
      .y_o       (y_o[b*DATA_W +: DATA_W]),
      .sw_en_o   (sw_en_o[b*NPORT +: NPORT]),
      .hold_o    (hold_o[b])
    );
  end

endmodule

// File: tb/dualbank_selmux_tb.sv
module dualbank_selmux_tb_top;

  localparam int NB = 2;
  localparam int NP = 4;
  localparam int DW = 8;

  logic            clk = 1'b0;
  logic            rst;
  logic            sync_mode;
  logic            clk_en_n;
  logic [1:0]      sel;
  logic [NB-1:0]   oe_n;
  logic [NB*NP*DW-1:0] pdata;
  logic [NB*DW-1:0]    y;
  logic [NB*NP-1:0]    sw_en;
  logic [NB-1:0]       hold;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  dualbank_selmux dut_i (
    .clk_i       (clk),
    .rst_i       (rst),
    .sync_mode_i (sync_mode),
    .clk_en_n_i  (clk_en_n),
    .sel_i       (sel),
    .oe_n_i      (oe_n),
    .port_data_i (pdata),
    .y_o         (y),
    .sw_en_o     (sw_en),
    .hold_o      (hold)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_port(input int b, input int p, input logic [7:0] v);
    pdata[(b*NP+p)*DW +: DW] = v;
  endtask

  function automatic logic [7:0] y_of(input int b);
    return y[b*DW +: DW];
  endfunction

  function automatic logic [3:0] sw_of(input int b);
    return sw_en[b*NP +: NP];
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  // R9 reset state, then R1 port A after reset
  task automatic t_reset();
    rst = 1'b1; sync_mode = 1'b1; clk_en_n = 1'b1; sel = 2'd2; oe_n = 2'b11;
    tick(); tick();
    rst = 1'b0;
    tick();
    check("R9 y bank0 zero", 32'(y_of(0)), 32'h00);
    check("R9 y bank1 zero", 32'(y_of(1)), 32'h00);
    check("R9 hold flags", 32'(hold), 32'h3);
    check("R8 no switch when off", 32'(sw_en), 32'h00);
    oe_n = 2'b00;
    #1;
    check("R9 select at port A", 32'(sw_of(0)), 32'h1);
    check("R1 code 0 -> A bank0", 32'(y_of(0)), 32'hA0);
    check("R1 code 0 -> A bank1", 32'(y_of(1)), 32'h1A);
    check("R8 hold low when linked", 32'(hold), 32'h0);
  endtask

  // R4 direct mode, R7 break cycle, R1 mapping
  task automatic t_direct();
    tick();
    sync_mode = 1'b0; sel = 2'd2;
    #1;
    check("R7 dark cycle bank0", 32'(sw_of(0)), 32'h0);
    check("R7 held value bank0", 32'(y_of(0)), 32'hA0);
    check("R7 held value bank1", 32'(y_of(1)), 32'h1A);
    check("R8 hold flags in break", 32'(hold), 32'h3);
    tick();
    check("R4 direct C bank0 sw", 32'(sw_of(0)), 32'h4);
    check("R1 code 2 -> C bank0", 32'(y_of(0)), 32'hC2);
    check("R1 code 2 -> C bank1", 32'(y_of(1)), 32'h3C);
    sel = 2'd3;
    tick();
    check("R1 code 3 -> D", 32'(y_of(0)), 32'hD3);
    sel = 2'd1;
    tick();
    check("R1 code 1 -> B", 32'(y_of(0)), 32'hB1);
    check("R4 B switch", 32'(sw_of(0)), 32'h2);
    sel = 2'd0;
    tick();
    check("R4 back to A", 32'(y_of(0)), 32'hA0);
  endtask

  // R2 registered capture
  task automatic t_regd();
    sync_mode = 1'b1; clk_en_n = 1'b0; sel = 2'd0;
    tick();
    check("R2 mode entry keeps A", 32'(sw_of(0)), 32'h1);
    sel = 2'd3;
    #1;
    check("R2 no change before edge", 32'(sw_of(0)), 32'h1);
    check("R2 still A before edge", 32'(y_of(0)), 32'hA0);
    tick();
    check("R7 dark after capture", 32'(sw_of(0)), 32'h0);
    check("R7 shows held A", 32'(y_of(0)), 32'hA0);
    tick();
    check("R2 D linked", 32'(sw_of(0)), 32'h8);
    check("R2 D data", 32'(y_of(0)), 32'hD3);
  endtask

  // R3 capture disabled
  task automatic t_keep();
    clk_en_n = 1'b1; sel = 2'd1;
    tick(); tick();
    check("R3 register kept", 32'(sw_of(0)), 32'h8);
    check("R3 output still D", 32'(y_of(0)), 32'hD3);
    set_port(0, 3, 8'h5E);
    #1;
    check("R3 follows live data", 32'(y_of(0)), 32'h5E);
  endtask

  // R5 off override, R6 hold, R10 independence
  task automatic t_off();
    tick();
    oe_n = 2'b01; clk_en_n = 1'b0; sel = 2'd3;
    #1;
    check("R5 bank0 opens at once", 32'(sw_of(0)), 32'h0);
    check("R5 bank0 hold flag", 32'(hold), 32'h1);
    check("R10 bank1 still linked", 32'(sw_of(1)), 32'h8);
    set_port(0, 3, 8'h77);
    tick(); tick();
    check("R6 held despite data change", 32'(y_of(0)), 32'h5E);
    check("R10 bank1 output", 32'(y_of(1)), 32'h4D);
    oe_n = 2'b00;
    #1;
    check("R5 reconnect without dark", 32'(sw_of(0)), 32'h8);
    check("R5 live data after reconnect", 32'(y_of(0)), 32'h77);
    tick();
    oe_n = 2'b10;
    set_port(1, 3, 8'h99);
    tick();
    check("R6 bank1 held", 32'(y_of(1)), 32'h4D);
    check("R10 bank0 unaffected", 32'(y_of(0)), 32'h77);
  endtask

  initial begin
    rst = 1'b1; sync_mode = 1'b1; clk_en_n = 1'b1; sel = '0; oe_n = '1; pdata = '0;
    set_port(0, 0, 8'hA0); set_port(0, 1, 8'hB1); set_port(0, 2, 8'hC2); set_port(0, 3, 8'hD3);
    set_port(1, 0, 8'h1A); set_port(1, 1, 8'h2B); set_port(1, 2, 8'h3C); set_port(1, 3, 8'h4D);
    t_reset();
    t_direct();
    t_regd();
    t_keep();
    t_off();
    tick();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule